// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block lets synchronous logic use an asynchronous page-mode DRAM array that is 64 bits wide and split into eight byte lanes. A host hands over one request at a time: a 12-bit row, a 10-bit column, a write flag, 64 bits of write data and eight byte enables. The sequencer drives the multiplexed address bus, one shared row strobe (RAS), eight per-lane column strobes (CAS), the write enable and the output enable. Every analog timing limit becomes a whole number of clock cycles, rounded up from nanosecond parameters at the configured clock period.

A row stays open after an access. Later requests to the same row are served as page-mode column cycles, and RAS stays low between them. A request for another row, a pending refresh request, or RAS nearing its maximum low time closes the row. The precharge time is then met before any new row opens. Writes are always early writes: WE falls before CAS, so the DRAM never drives its data pins. Reads hold CAS and OE low until the CAS, column-address and RAS access times have all passed. The sampled word then comes back as a one-cycle pulse.

The request port uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields are stored at that edge. The host must hold the request stable while `req_ready` is low. The response has no back-pressure: `rsp_valid` is high for exactly one cycle and the host must take `rsp_rdata` in that cycle. Refresh uses a plain handshake: `ref_req` high asks for the array, and `ref_grant` answers once the row is closed and precharged.

Top module: `hpdram_seq`

## Requirements
- R1: While and after reset, RAS, all eight CAS lanes, WE and OE are high (inactive), `dram_dq_oe` is low, `rsp_valid` and `ref_grant` are low, and `req_ready` is high.
- R2: A row is opened by RAS falling with the row address on `dram_addr[11:0]`. The address and RAS hold for at least the next cycle. No CAS falls earlier than 2 cycles after RAS (14 ns at 10 ns per cycle), and CAS is never low while RAS is high.
- R3: A request to the row that is already open is served without RAS rising. Successive CAS falls are at least 2 cycles apart (20 ns page cycle), and CAS stays high at least 1 cycle (8 ns) between column accesses.
- R4: For both reads and writes, CAS lane i (bit i of `dram_cas_n`) goes low only when `req_be[i]` was set. Lane i gates data bits 8i+7 to 8i.
- R5: A write is an early write. WE is low at least one cycle before CAS falls. While CAS is low, OE stays high, `dram_dq_oe` is high and `dram_dq_out` carries the stored write data. WE and OE are never low together.
- R6: A read holds OE and CAS low until 13 ns after CAS fell, 25 ns after the column address appeared and 50 ns after RAS fell have all passed. The word sampled then is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R7: A request for a different row closes the open row. RAS is low for at least 5 cycles (50 ns) and high for at least 3 cycles (30 ns) before it falls again.
- R8: RAS is never low longer than the maximum low time (default 100000 ns = 10000 cycles). The row is closed before that limit even when every request hits it.
- R9: While `ref_req` is high, `req_ready` is low and no request is accepted. `ref_grant` goes high only with RAS high and after the precharge time has passed.
- R10: Row, column, write flag, data and byte enables are stored at acceptance, so changing the request inputs afterwards has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timings are counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_row | input | 12 | Row address of the request |
| req_col | input | 10 | Column address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables, bit i selects data bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 64 | Read data |
| ref_req | input | 1 | Refresh logic asks for the array |
| ref_grant | output | 1 | Array idle, row closed and precharged |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 8 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 64 | Data driven to the array |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 64 | Data returned by the array |

## Verification
The assertions watch the relations that must hold on every cycle: CAS never low without RAS, WE never low together with OE, WE already low before a write CAS falls, the row address held after RAS falls, the one-cycle response pulse, RAS kept high while refresh is granted, no acceptance while refresh is requested, and RAS low time within its limit. Only the bench scenarios can show the things that need a data model or an intended order of events. These are data arriving only once all three access times have passed, byte lanes merging in memory, page hits keeping RAS low, row misses and the low-time limit closing the row, and request fields changed after acceptance being ignored.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COLSET,
    ST_COL,
    ST_OPEN,
    ST_PRE
  } hpd_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hpd_phase_timer.sv
module hpd_phase_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/hpd_row_timer.sv
module hpd_row_timer #(
  parameter int P_RAC    = 5,
  parameter int P_RASMIN = 5,
  parameter int P_RASMAX = 10000,
  parameter int P_GUARD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic rac_ok,
  output logic min_ok,
  output logic lim_hit
);
  localparam int AW = $clog2(P_RASMAX + 2);

  // cycles RAS has already been low before the current one
  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       age_q <= '0;
    else if (!ras_low)                age_q <= '0;
    else if (age_q != {AW{1'b1}})     age_q <= age_q + 1'b1;
  end

  assign rac_ok  = (int'(age_q) + 1 >= P_RAC);
  assign min_ok  = (int'(age_q) + 1 >= P_RASMIN);
  assign lim_hit = (int'(age_q) + 1 + P_GUARD > P_RASMAX);

  // R8: the current low cycle never pushes RAS past its limit
  assert_ras_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (int'(age_q) < P_RASMAX));
endmodule

// File: rtl/hpd_lane_strobe.sv
module hpd_lane_strobe #(
  parameter int LANES = 8
) (
  input  logic             strobe,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] cas_n
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n[g] = ~(strobe & lane_en[g]);
  end
endmodule

// File: rtl/hpdram_seq.sv
module hpdram_seq
  import hpd_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int LANES       = 8,
  parameter int T_RCD_NS    = 14,
  parameter int T_RP_NS     = 30,
  parameter int T_CAS_NS    = 8,
  parameter int T_CAC_NS    = 13,
  parameter int T_AA_NS     = 25,
  parameter int T_RAC_NS    = 50,
  parameter int T_RASMIN_NS = 50,
  parameter int T_RASMAX_NS = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic                 req_write,
  input  logic [LANES*8-1:0]   req_wdata,
  input  logic [LANES-1:0]     req_be,
  output logic                 rsp_valid,
  output logic [LANES*8-1:0]   rsp_rdata,
  input  logic                 ref_req,
  output logic                 ref_grant,
  output logic [ROW_W-1:0]     dram_addr,
  output logic                 dram_ras_n,
  output logic [LANES-1:0]     dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [LANES*8-1:0]   dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [LANES*8-1:0]   dram_dq_in
);
  localparam int DW       = LANES * 8;
  localparam int P_RCD    = ns_to_cyc(T_RCD_NS, CLK_NS);
  localparam int P_RP     = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int P_CASW   = imax(ns_to_cyc(T_CAS_NS, CLK_NS), 1);
  localparam int P_CAC    = ns_to_cyc(T_CAC_NS, CLK_NS);
  localparam int P_AA     = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int P_RAC    = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int P_RASMIN = ns_to_cyc(T_RASMIN_NS, CLK_NS);
  localparam int P_RASMAX = T_RASMAX_NS / CLK_NS;
  // the column address is driven one cycle before CAS falls
  localparam int P_COLRD  = imax(imax(P_CAC, P_AA - 1), P_CASW);
  localparam int P_COLMAX = imax(P_COLRD, P_CASW);
  localparam int P_GUARD  = P_COLMAX + 2;
  localparam int TW       = $clog2(imax(P_RCD, P_RP) + 1);
  localparam int CW       = $clog2(P_COLMAX + 2);
  localparam logic [CW-1:0] C_CASW  = CW'(P_CASW);
  localparam logic [CW-1:0] C_COLRD = CW'(P_COLRD);
  localparam logic [TW-1:0] C_RCD1  = TW'(P_RCD - 1);
  localparam logic [TW-1:0] C_RP1   = TW'(P_RP - 1);

  hpd_state_e          state_q, state_d;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic                wr_q;
  logic [DW-1:0]       wdata_q;
  logic [LANES-1:0]    be_q;
  logic [CW-1:0]       col_cnt;
  logic [DW-1:0]       rdata_q;
  logic                rsp_q;

  logic                accept, col_exit, t_load, t_done, hit;
  logic [TW-1:0]       t_val;
  logic                ras_low_w, col_phase, strobe;
  logic                rac_ok, min_ok, lim_hit, cas_any;

  assign hit = (req_row == row_q);

  // ---------------- next-state decision ----------------
  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    accept   = 1'b0;
    col_exit = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!ref_req && req_valid) begin
          accept  = 1'b1;
          state_d = ST_ACT;
          t_load  = 1'b1;
          t_val   = C_RCD1;
        end
      end
      ST_ACT:    if (t_done) state_d = ST_COLSET;
      ST_COLSET: state_d = ST_COL;
      ST_COL: begin
        if (wr_q ? (col_cnt >= C_CASW) : ((col_cnt >= C_COLRD) && rac_ok)) begin
          col_exit = 1'b1;
          state_d  = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (ref_req || lim_hit || (req_valid && !hit)) begin
          if (min_ok) begin
            state_d = ST_PRE;
            t_load  = 1'b1;
            t_val   = C_RP1;
          end
        end else if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_COLSET;
        end
      end
      ST_PRE:    if (t_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign req_ready = !ref_req &&
                     ((state_q == ST_IDLE) || ((state_q == ST_OPEN) && hit && !lim_hit));
  assign ref_grant = ref_req && (state_q == ST_IDLE);

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
      col_cnt <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      col_cnt <= (state_q == ST_COL) ? col_cnt + 1'b1 : CW'(1);
      rsp_q   <= col_exit && !wr_q;
      if (col_exit && !wr_q) rdata_q <= dram_dq_in;
      if (accept) begin
        row_q   <= req_row;
        col_q   <= req_col;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  hpd_phase_timer #(.W(TW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  hpd_row_timer #(
    .P_RAC    (P_RAC),
    .P_RASMIN (P_RASMIN),
    .P_RASMAX (P_RASMAX),
    .P_GUARD  (P_GUARD)
  ) u_row (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_low (ras_low_w),
    .rac_ok  (rac_ok),
    .min_ok  (min_ok),
    .lim_hit (lim_hit)
  );

  // ---------------- pin decode ----------------
  assign ras_low_w = (state_q == ST_ACT) || (state_q == ST_COLSET) ||
                     (state_q == ST_COL) || (state_q == ST_OPEN);
  assign col_phase = (state_q == ST_COLSET) || (state_q == ST_COL);
  assign strobe    = (state_q == ST_COL);

  assign dram_ras_n  = ~ras_low_w;
  assign dram_addr   = col_phase ? ROW_W'(col_q) : row_q;
  assign dram_we_n   = ~(col_phase & wr_q);
  assign dram_oe_n   = ~(strobe & ~wr_q);
  assign dram_dq_oe  = col_phase & wr_q;
  assign dram_dq_out = wdata_q;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;

  hpd_lane_strobe #(.LANES(LANES)) u_lanes (
    .strobe  (strobe),
    .lane_en (be_q),
    .cas_n   (dram_cas_n)
  );

  assign cas_any = (dram_cas_n != {LANES{1'b1}});

  // ---------------- assertions ----------------
  assert_cas_under_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_any |-> !dram_ras_n);

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |=> (!dram_ras_n && $stable(dram_addr)));

  assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n));

  assert_write_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_any) && !dram_we_n) |-> $past(!dram_we_n));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_grant_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> dram_ras_n);

  assert_refresh_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);
endmodule

// File: tb/hpdram_seq_test.sv
module hpdram_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int RASMAX_CYC = 200;   // bench overrides the limit to 2000 ns
  localparam int RCD_CYC    = 2;
  localparam int RP_CYC     = 3;
  localparam int HPC_CYC    = 2;
  localparam int RASMIN_CYC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        ref_req = 1'b0;
  logic        ref_grant;
  logic [11:0] dram_addr;
  logic        dram_ras_n;
  logic [7:0]  dram_cas_n;
  logic        dram_we_n, dram_oe_n, dram_dq_oe;
  logic [63:0] dram_dq_out, dram_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpdram_seq #(.T_RASMAX_NS(RASMAX_CYC * CLK_PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_grant(ref_grant),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // ---------------- DRAM model ----------------
  logic [63:0] mem [0:31];
  logic [11:0] row_l = '0;
  logic [11:0] addr_prev = '0;
  logic [7:0]  cas_prev = 8'hFF;
  logic        ras_prev_m = 1'b1;
  int ras_c = 0, cas_c = 0, addr_c = 0;
  logic [4:0]  midx;
  logic        mvalid;

  initial for (int i = 0; i < 32; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (!dram_ras_n && ras_prev_m) row_l <= dram_addr;
    for (int i = 0; i < 8; i++)
      if (!dram_cas_n[i] && cas_prev[i] && !dram_we_n)
        mem[{row_l[1:0], dram_addr[2:0]}][8*i +: 8] <= dram_dq_out[8*i +: 8];
    ras_c      <= dram_ras_n ? 0 : ras_c + 1;
    cas_c      <= (&dram_cas_n) ? 0 : cas_c + 1;
    addr_c     <= (dram_addr != addr_prev) ? 1 : addr_c + 1;
    addr_prev  <= dram_addr;
    cas_prev   <= dram_cas_n;
    ras_prev_m <= dram_ras_n;
  end

  assign midx   = {row_l[1:0], dram_addr[2:0]};
  assign mvalid = ((cas_c + 1) * CLK_PERIOD >= 13) && ((addr_c + 1) * CLK_PERIOD >= 25) &&
                  ((ras_c + 1) * CLK_PERIOD >= 50) && !dram_oe_n && dram_we_n && !(&dram_cas_n);
  assign dram_dq_in = mvalid ? mem[midx] : 64'hBADD_BADD_BADD_BADD;

  // ---------------- strobe monitor ----------------
  logic [11:0] exp_row = '0;
  logic [7:0]  exp_be = '0;
  logic [63:0] exp_wdata = '0;
  int mon_cyc = 0, ras_lo = 0, ras_hi = 100, ras_fall_cyc = 0, last_cas_cyc = -100;
  int ras_rises = 0;
  bit row_chk = 0, prv_ras = 1, prv_cas = 0, prv_we = 1;

  always @(negedge clk) if (rst_n) begin
    bit cas_any;
    cas_any = (dram_cas_n != 8'hFF);
    if (ref_grant) chk(dram_ras_n, "R9 grant with RAS high", 64'(dram_ras_n), 64'd1);
    if (cas_any) chk(!dram_ras_n, "R2 CAS only under RAS", 64'(dram_ras_n), 64'd0);
    if (row_chk) begin
      chk(!dram_ras_n && dram_addr == exp_row, "R2 row address hold", 64'(dram_addr), 64'(exp_row));
      row_chk = 0;
    end
    if (prv_ras && !dram_ras_n) begin
      chk(ras_hi >= RP_CYC, "R7 precharge length", 64'(ras_hi), 64'(RP_CYC));
      chk(dram_addr == exp_row, "R2 row address at RAS fall", 64'(dram_addr), 64'(exp_row));
      row_chk = 1;
      ras_fall_cyc = mon_cyc;
      last_cas_cyc = -100;
    end
    if (!prv_ras && dram_ras_n) begin
      chk(ras_lo >= RASMIN_CYC, "R7 RAS minimum low", 64'(ras_lo), 64'(RASMIN_CYC));
      chk(ras_lo <= RASMAX_CYC, "R8 RAS maximum low", 64'(ras_lo), 64'(RASMAX_CYC));
      ras_rises++;
    end
    if (!prv_cas && cas_any) begin
      chk(mon_cyc - ras_fall_cyc >= RCD_CYC, "R2 RAS to CAS delay",
          64'(mon_cyc - ras_fall_cyc), 64'(RCD_CYC));
      chk(mon_cyc - last_cas_cyc >= HPC_CYC, "R3 page cycle",
          64'(mon_cyc - last_cas_cyc), 64'(HPC_CYC));
      last_cas_cyc = mon_cyc;
      chk(dram_cas_n == ~exp_be, "R4 CAS lanes", 64'(dram_cas_n), 64'(~exp_be));
      if (!dram_we_n) begin
        chk(!prv_we, "R5 WE setup before CAS", 64'(prv_we), 64'd0);
        chk(dram_oe_n && dram_dq_oe, "R5 OE high and driver on",
            64'({dram_oe_n, dram_dq_oe}), 64'd3);
        chk(dram_dq_out == exp_wdata, "R5 write data", dram_dq_out, exp_wdata);
      end else begin
        chk(!dram_oe_n && !dram_dq_oe, "R6 read OE low, driver off",
            64'({dram_oe_n, dram_dq_oe}), 64'd0);
      end
    end
    if (dram_ras_n) begin ras_hi++; ras_lo = 0; end
    else            begin ras_lo++; ras_hi = 0; end
    prv_ras = dram_ras_n;
    prv_cas = cas_any;
    prv_we  = dram_we_n;
    mon_cyc++;
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  // ---------------- request tasks ----------------
  task automatic issue(input logic [11:0] row, input logic [9:0] col, input bit wr,
                       input logic [63:0] data, input logic [7:0] be);
    @(negedge clk);
    exp_row = row; exp_be = be; exp_wdata = data;
    req_row = row; req_col = col; req_write = wr; req_wdata = data; req_be = be;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    // R10: scramble every request field once the request is taken
    req_valid = 1'b0;
    req_wdata = ~data;
    req_be    = ~be;
    req_col   = ~col;
    req_write = ~wr;
  endtask

  task automatic wr(input logic [11:0] row, input logic [9:0] col,
                    input logic [63:0] data, input logic [7:0] be);
    issue(row, col, 1'b1, data, be);
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] row, input logic [9:0] col,
                    input logic [63:0] exp, input string tag);
    int t = 0;
    issue(row, col, 1'b0, '0, 8'hFF);
    while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
    chk(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R6 response is one cycle", 64'(rsp_valid), 64'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 8'hFF && dram_we_n && dram_oe_n && !dram_dq_oe,
        "R1 strobes idle", 64'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe}),
        64'({1'b1, 8'hFF, 1'b1, 1'b1, 1'b0}));
    chk(req_ready && !rsp_valid && !ref_grant, "R1 handshake idle",
        64'({req_ready, rsp_valid, ref_grant}), 64'b100);
  endtask

  task automatic t_page;
    int r0;
    wr(12'd5, 10'd1, 64'h0123_4567_89AB_CDEF, 8'hFF);
    r0 = ras_rises;
    wr(12'd5, 10'd2, 64'hFEDC_BA98_7654_3210, 8'hFF);
    rd(12'd5, 10'd1, 64'h0123_4567_89AB_CDEF, "R6 read data col1 (R10 fields held)");
    rd(12'd5, 10'd2, 64'hFEDC_BA98_7654_3210, "R6 read data col2");
    chk(ras_rises == r0, "R3 page hits keep RAS low", 64'(ras_rises - r0), 64'd0);
  endtask

  task automatic t_lanes;
    wr(12'd5, 10'd3, 64'h1111_1111_1111_1111, 8'hFF);
    wr(12'd5, 10'd3, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F);
    rd(12'd5, 10'd3, 64'h1111_1111_AAAA_AAAA, "R4 byte-lane merge");
    wr(12'd5, 10'd3, 64'h5555_5555_5555_5555, 8'h81);
    rd(12'd5, 10'd3, 64'h5511_1111_AAAA_AA55, "R4 outer lanes");
  endtask

  task automatic t_miss;
    int r0;
    r0 = ras_rises;
    wr(12'd6, 10'd1, 64'hCAFE_F00D_0000_0001, 8'hFF);
    chk(ras_rises > r0, "R7 row miss closes row", 64'(ras_rises - r0), 64'd1);
    rd(12'd5, 10'd1, 64'h0123_4567_89AB_CDEF, "R7 old row after miss");
    rd(12'd6, 10'd1, 64'hCAFE_F00D_0000_0001, "R7 new row after miss");
  endtask

  task automatic t_refresh;
    int t = 0;
    @(negedge clk);
    ref_req = 1'b1;
    #1;
    chk(!req_ready, "R9 no ready under refresh", 64'(req_ready), 64'd0);
    while (!ref_grant && t < 30) begin @(negedge clk); t++; end
    chk(ref_grant && dram_ras_n, "R9 grant after close",
        64'({ref_grant, dram_ras_n}), 64'b11);
    req_row = 12'd5; req_col = 10'd2; req_write = 1'b1; req_be = 8'hFF;
    req_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(dram_ras_n && !req_ready && dram_cas_n == 8'hFF, "R9 request ignored during grant",
          64'({dram_ras_n, req_ready}), 64'b10);
    end
    req_valid = 1'b0;
    ref_req = 1'b0;
    rd(12'd5, 10'd2, 64'hFEDC_BA98_7654_3210, "R9 data kept across refresh");
  endtask

  task automatic t_rasmax;
    int r0;
    r0 = ras_rises;
    for (int i = 0; i < 60; i++)
      rd(12'd5, 10'd1, 64'h0123_4567_89AB_CDEF, "R8 hit stream data");
    chk(ras_rises > r0, "R8 limit closes a busy row", 64'(ras_rises - r0), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_page();
    t_lanes();
    t_miss();
    t_refresh();
    t_rasmax();
    repeat (10) @(negedge clk);
    report();
    $finish;
  end
endmodule